// File: doc/BRIEF.md
# SMBus Pointer-Register Slave

This block is the serial-bus front end of a register file. It watches the clock and data lines of a two-wire management bus. It recognises start, stop and repeated-start conditions and answers one 7-bit slave address. The address is picked by two strap inputs. It turns the byte protocols it accepts into single-cycle accesses on a plain register-file port. An 8-bit pointer selects the register. The first byte of every write goes into the pointer. A second byte, if one follows, is stored at that pointer. A read returns the byte at the pointer and leaves the pointer unchanged.

The block keeps a shadow copy of two bits of the configuration register at pointer 0x40. Bit 6 enables an idle timeout: when the bus stops moving in the middle of a transaction, the slave lets go of the data line. Bit 1 is a one-way lock. Once it is set, writes to the protected register window are dropped until the next reset. Both line inputs pass through a two-stage synchroniser into the system clock domain. The data line is driven only through an open-drain pull-down enable.

Top module: `smb_ptr_slave`

## Requirements
- R1: With `strapEn` high the slave address is 0x2E. With `strapEn` low it is 0x2C when `strapSel` is 0 and 0x2D when `strapSel` is 1. A matching address byte is acknowledged by raising `sdaOe` during the 9th clock. A non-matching address is never acknowledged.
- R2: The address is fixed at the rising clock edge that begins the 8th bit of the first address byte that matches. Strap changes after that have no effect: the fixed address keeps being acknowledged and the new strap address is not.
- R3: In a write (address byte with R/W bit 0), the first byte loads the pointer and the second byte produces exactly one `regWrEn` pulse of one cycle, with `regAddr` equal to the pointer and `regWrData` equal to the byte. Both bytes are acknowledged.
- R4: In a read (R/W bit 1), the byte `regRdData` at the current pointer is shifted out MSB first. The slave pulls SDA low for each 0 bit. A read does not change the pointer.
- R5: A write that carries only the pointer byte loads the pointer and causes no register write.
- R6: Any byte after the second byte of a write is not acknowledged and is not written.
- R7: A repeated start after the pointer byte begins a new transaction at once, so a read can follow with no stop in between.
- R8: Writing the register at pointer 0x40 copies bit 6 into the timeout enable. With the enable set, a transaction that sees no edge on either line for `TO_CYCLES` clocks is abandoned: SDA is released and the slave goes idle. With the enable clear, SDA stays driven.
- R9: Writing 1 to bit 1 of the register at pointer 0x40 sets a lock. The write that sets it still lands. After that, writes to pointers 0x40 to 0x7F are dropped until reset. Writes outside that window are unaffected.
- R10: After reset `sdaOe` and `regWrEn` are low and `regAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| strapEn | input | 1 | Strap: high selects the fixed default address |
| strapSel | input | 1 | Strap: chooses between the two alternate addresses |
| sdaOe | output | 1 | Pull the data line low when 1 |
| regAddr | output | 8 | Register-file address (the pointer) |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrData | output | 8 | Register write data |
| regRdData | input | 8 | Register-file read data at `regAddr` |

## Verification
The lock-setting write and the lock check fall in the same cycle. The byte written to 0x40 that sets the lock is itself inside the protected window, so it must still be judged against the lock's value before the write. The bench provokes this by writing 0x42 to 0x40 and reading it back: 0x42 must be present. A later write to 0x45 must leave its old value and a write to 0x10 must land. The other close pair is a pointer load followed at once by a read fetch over a repeated start. Each read value is compared with a bench-side memory model that only changes when a write is expected to land.

// File: rtl/smb_ptr_pkg.sv
package smb_ptr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
    ST_DATA, ST_DATA_ACK, ST_TX, ST_TX_ACK, ST_SKIP
  } smbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrBits;
    logic shiftIn;
    logic latchAddr;
    logic loadPtr;
    logic wrStrobe;
    logic loadTx;
    logic shiftTx;
  } smbStrobe_t;

  // events from datapath to control
  typedef struct packed {
    logic       startDet;
    logic       stopDet;
    logic       sclRise;
    logic       sclFall;
    logic [3:0] bitCnt;
    logic       addrHit;
    logic       rwBit;
    logic       txBit;
    logic       timeoutHit;
  } smbEvent_t;

endpackage

// File: rtl/smb_ptr_dp.sv
module smb_ptr_dp
  import smb_ptr_pkg::*;
#(
  parameter logic [6:0] ADDR_DEF  = 7'h2E,
  parameter logic [6:0] ADDR_SEL0 = 7'h2C,
  parameter logic [6:0] ADDR_SEL1 = 7'h2D,
  parameter logic [7:0] CFG_ADDR  = 8'h40,
  parameter int         TO_BIT    = 6,
  parameter int         LOCK_BIT  = 1,
  parameter logic [7:0] LOCK_LO   = 8'h40,
  parameter logic [7:0] LOCK_HI   = 8'h7F,
  parameter int         TO_CYCLES = 3500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       strapEn,
  input  logic       strapSel,
  input  logic       busBusy,
  input  smbStrobe_t strb,
  output smbEvent_t  ev,
  output logic [7:0] regAddr,
  output logic       regWrEn,
  output logic [7:0] regWrData,
  input  logic [7:0] regRdData,
  output logic       addrLocked,
  output logic [6:0] slvAddr,
  output logic       lockBit
);

  localparam int        TO_W    = $clog2(TO_CYCLES + 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(TO_CYCLES - 1);

  logic [2:0] sclQ, sdaQ;
  logic [7:0] shiftReg, ptr, txReg;
  logic [3:0] bitCnt;
  logic [TO_W-1:0] toCnt;
  logic toEn;
  logic [6:0] candAddr, matchAddr;
  logic wrBlocked, anyEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 3'b111;
      sdaQ <= 3'b111;
    end else begin
      sclQ <= {sclQ[1:0], sclIn};
      sdaQ <= {sdaQ[1:0], sdaIn};
    end
  end

  assign candAddr  = strapEn ? ADDR_DEF : (strapSel ? ADDR_SEL1 : ADDR_SEL0);
  assign matchAddr = addrLocked ? slvAddr : candAddr;
  assign wrBlocked = lockBit && (ptr >= LOCK_LO) && (ptr <= LOCK_HI);
  assign anyEdge   = (sclQ[1] ^ sclQ[2]) | (sdaQ[1] ^ sdaQ[2]);
  assign regAddr   = ptr;

  always_comb begin
    ev.sclRise    = sclQ[1] & ~sclQ[2];
    ev.sclFall    = ~sclQ[1] & sclQ[2];
    ev.startDet   = ~sdaQ[1] & sdaQ[2] & sclQ[1];
    ev.stopDet    = sdaQ[1] & ~sdaQ[2] & sclQ[1];
    ev.bitCnt     = bitCnt;
    ev.addrHit    = (shiftReg[6:0] == matchAddr);
    ev.rwBit      = sdaQ[1];
    ev.txBit      = txReg[7];
    ev.timeoutHit = toEn && busBusy && (toCnt == TO_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      bitCnt     <= '0;
      ptr        <= '0;
      txReg      <= '1;
      addrLocked <= 1'b0;
      slvAddr    <= ADDR_DEF;
      regWrEn    <= 1'b0;
      regWrData  <= '0;
      toEn       <= 1'b0;
      lockBit    <= 1'b0;
      toCnt      <= '0;
    end else begin
      if (strb.clrBits)      bitCnt <= '0;
      else if (strb.shiftIn) bitCnt <= bitCnt + 4'd1;
      if (strb.shiftIn) shiftReg <= {shiftReg[6:0], sdaQ[1]};

      if (strb.latchAddr && !addrLocked) begin
        addrLocked <= 1'b1;
        slvAddr    <= candAddr;
      end

      if (strb.loadPtr) ptr <= shiftReg;

      regWrEn   <= strb.wrStrobe && !wrBlocked;
      regWrData <= shiftReg;
      if (strb.wrStrobe && !wrBlocked && ptr == CFG_ADDR) begin
        toEn    <= shiftReg[TO_BIT];
        lockBit <= lockBit | shiftReg[LOCK_BIT];
      end

      if (strb.loadTx)       txReg <= regRdData;
      else if (strb.shiftTx) txReg <= {txReg[6:0], 1'b1};

      if (!busBusy || anyEdge)  toCnt <= '0;
      else if (toCnt != TO_LAST) toCnt <= toCnt + 1'b1;
    end
  end

endmodule

// File: rtl/smb_ptr_ctrl.sv
module smb_ptr_ctrl
  import smb_ptr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  smbEvent_t  ev,
  output smbStrobe_t strb,
  output logic       sdaOe,
  output logic       busBusy
);

  smbState_t state, nxt;
  logic hitQ, rwQ;

  always_comb begin
    nxt  = state;
    strb = '0;
    if (ev.stopDet) begin
      nxt = ST_IDLE;
    end else if (ev.startDet) begin
      nxt = ST_ADDR;
      strb.clrBits = 1'b1;
    end else if (ev.timeoutHit) begin
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR: begin
          if (ev.sclRise && ev.bitCnt < 4'd8) strb.shiftIn = 1'b1;
          if (ev.sclRise && ev.bitCnt == 4'd7 && ev.addrHit) strb.latchAddr = 1'b1;
          if (ev.sclFall && ev.bitCnt == 4'd8) begin
            strb.clrBits = 1'b1;
            nxt = hitQ ? ST_ADDR_ACK : ST_SKIP;
          end
        end
        ST_ADDR_ACK: if (ev.sclFall) begin
          strb.clrBits = 1'b1;
          if (rwQ) begin
            strb.loadTx = 1'b1;
            nxt = ST_TX;
          end else begin
            nxt = ST_PTR;
          end
        end
        ST_PTR: begin
          if (ev.sclRise && ev.bitCnt < 4'd8) strb.shiftIn = 1'b1;
          if (ev.sclFall && ev.bitCnt == 4'd8) begin
            strb.loadPtr = 1'b1;
            strb.clrBits = 1'b1;
            nxt = ST_PTR_ACK;
          end
        end
        ST_PTR_ACK: if (ev.sclFall) nxt = ST_DATA;
        ST_DATA: begin
          if (ev.sclRise && ev.bitCnt < 4'd8) strb.shiftIn = 1'b1;
          if (ev.sclFall && ev.bitCnt == 4'd8) begin
            strb.wrStrobe = 1'b1;
            strb.clrBits  = 1'b1;
            nxt = ST_DATA_ACK;
          end
        end
        ST_DATA_ACK: if (ev.sclFall) nxt = ST_SKIP;
        ST_TX: begin
          if (ev.sclRise && ev.bitCnt < 4'd8) strb.shiftIn = 1'b1;
          if (ev.sclFall) begin
            if (ev.bitCnt == 4'd8) nxt = ST_TX_ACK;
            else                   strb.shiftTx = 1'b1;
          end
        end
        ST_TX_ACK: if (ev.sclFall) nxt = ST_SKIP;
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      hitQ  <= 1'b0;
      rwQ   <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_ADDR && ev.sclRise && ev.bitCnt == 4'd7) begin
        hitQ <= ev.addrHit;
        rwQ  <= ev.rwBit;
      end
    end
  end

  assign sdaOe = (state == ST_ADDR_ACK) || (state == ST_PTR_ACK) ||
                 (state == ST_DATA_ACK) || (state == ST_TX && !ev.txBit);
  assign busBusy = (state != ST_IDLE);

endmodule

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave
  import smb_ptr_pkg::*;
#(
  parameter logic [6:0] ADDR_DEF  = 7'h2E,
  parameter logic [6:0] ADDR_SEL0 = 7'h2C,
  parameter logic [6:0] ADDR_SEL1 = 7'h2D,
  parameter logic [7:0] CFG_ADDR  = 8'h40,
  parameter int         TO_BIT    = 6,
  parameter int         LOCK_BIT  = 1,
  parameter logic [7:0] LOCK_LO   = 8'h40,
  parameter logic [7:0] LOCK_HI   = 8'h7F,
  parameter int         TO_CYCLES = 3500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       strapEn,
  input  logic       strapSel,
  output logic       sdaOe,
  output logic [7:0] regAddr,
  output logic       regWrEn,
  output logic [7:0] regWrData,
  input  logic [7:0] regRdData
);

  smbStrobe_t ctlStrb;
  smbEvent_t  dpEv;
  logic       busBusy;
  logic       addrLocked;
  logic [6:0] slvAddr;
  logic       lockBit;
  logic       ptrLoad;
  logic       timeoutHit;

  assign ptrLoad    = ctlStrb.loadPtr;
  assign timeoutHit = dpEv.timeoutHit;

  smb_ptr_dp #(
    .ADDR_DEF(ADDR_DEF), .ADDR_SEL0(ADDR_SEL0), .ADDR_SEL1(ADDR_SEL1),
    .CFG_ADDR(CFG_ADDR), .TO_BIT(TO_BIT), .LOCK_BIT(LOCK_BIT),
    .LOCK_LO(LOCK_LO), .LOCK_HI(LOCK_HI), .TO_CYCLES(TO_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strapEn(strapEn), .strapSel(strapSel), .busBusy(busBusy),
    .strb(ctlStrb), .ev(dpEv),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData),
    .addrLocked(addrLocked), .slvAddr(slvAddr), .lockBit(lockBit)
  );

  smb_ptr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ev(dpEv), .strb(ctlStrb),
    .sdaOe(sdaOe), .busBusy(busBusy)
  );

endmodule

// File: rtl/smb_ptr_slave_chk.sv
module smb_ptr_slave_chk #(
  parameter logic [7:0] LOCK_LO = 8'h40,
  parameter logic [7:0] LOCK_HI = 8'h7F
) (
  input logic       clk,
  input logic       rstN,
  input logic       sdaOe,
  input logic       regWrEn,
  input logic [7:0] regAddr,
  input logic       addrLocked,
  input logic [6:0] slvAddr,
  input logic       lockBit,
  input logic       ptrLoad,
  input logic       timeoutHit
);

  // R2: once fixed, the slave address never moves
  a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    $past(addrLocked) |-> (addrLocked && $stable(slvAddr)));

  // R9: lock is sticky
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(lockBit) |-> lockBit);

  // R9: no write lands in the window once locked
  a_r9_window_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && $past(lockBit)) |-> !(regAddr >= LOCK_LO && regAddr <= LOCK_HI));

  // R4: pointer moves only after a pointer load
  a_r4_ptr_only_on_load: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ptrLoad) |-> $stable(regAddr));

  // R8: timeout releases the data line
  a_r8_timeout_release: assert property (@(posedge clk) disable iff (!rstN)
    timeoutHit |=> !sdaOe);

  // R3: write strobe is a single-cycle pulse
  a_r3_wr_pulse: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

endmodule

bind smb_ptr_slave smb_ptr_slave_chk #(.LOCK_LO(LOCK_LO), .LOCK_HI(LOCK_HI)) u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .regWrEn(regWrEn), .regAddr(regAddr),
  .addrLocked(addrLocked), .slvAddr(slvAddr), .lockBit(lockBit),
  .ptrLoad(ptrLoad), .timeoutHit(timeoutHit)
);

// File: tb/smb_ptr_slave_tb.sv
`timescale 1ns/1ps
module smb_ptr_slave_tb;

  localparam int TO_CYC = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic strapEn = 1'b1;
  logic strapSel = 1'b0;
  logic sdaOe;
  logic [7:0] regAddr, regWrData, regRdData;
  logic regWrEn;
  logic sdaLine;
  logic [7:0] mem [256];
  logic [7:0] expMem [256];
  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  assign sdaLine   = sdaM & ~sdaOe;
  assign regRdData = mem[regAddr];

  always @(posedge clk) if (regWrEn) mem[regAddr] <= regWrData;

  smb_ptr_slave #(.TO_CYCLES(TO_CYC)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .strapEn(strapEn), .strapSel(strapSel), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData)
  );

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic en, input logic sel);
    strapEn = en; strapSel = sel; scl = 1'b1; sdaM = 1'b1;
    rstN = 1'b0;
    waitc(5);
    rstN = 1'b1;
    waitc(5);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitc(5);
    scl = 1'b1; waitc(10);
    sdaM = 1'b0; waitc(10);
    scl = 1'b0; waitc(5);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitc(5);
    scl = 1'b1; waitc(10);
    sdaM = 1'b1; waitc(10);
  endtask

  task automatic bitOut(input logic b);
    sdaM = b; waitc(5);
    scl = 1'b1; waitc(10);
    scl = 1'b0; waitc(5);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bitOut(b[i]);
    sdaM = 1'b1; waitc(5);
    scl = 1'b1; waitc(5);
    ack = ~sdaLine;
    waitc(5);
    scl = 1'b0; waitc(5);
  endtask

  task automatic recvByte(output logic [7:0] b, input logic nack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; waitc(5);
      scl = 1'b1; waitc(5);
      b[i] = sdaLine;
      waitc(5);
      scl = 1'b0; waitc(5);
    end
    bitOut(nack);
  endtask

  function automatic logic [6:0] expAddr(input logic en, input logic sel);
    return en ? 7'h2E : (sel ? 7'h2D : 7'h2C);
  endfunction

  task automatic probe(input logic [6:0] a, output logic ack);
    logic [7:0] d;
    busStart();
    sendByte({a, 1'b1}, ack);
    if (ack) recvByte(d, 1'b1);
    busStop();
  endtask

  // write-byte at the strapped default address 0x2E
  task automatic wrByte(input logic [7:0] p, input logic [7:0] d, input string req);
    logic a;
    busStart();
    sendByte({7'h2E, 1'b0}, a); chk(req, a, 1);
    sendByte(p, a);             chk(req, a, 1);
    sendByte(d, a);             chk(req, a, 1);
    busStop();
  endtask

  // pointer write, repeated start, receive-byte (R7)
  task automatic rdAt(input logic [7:0] p, output logic [7:0] d);
    logic a;
    busStart();
    sendByte({7'h2E, 1'b0}, a); chk("R7", a, 1);
    sendByte(p, a);             chk("R7", a, 1);
    busStart();
    sendByte({7'h2E, 1'b1}, a); chk("R7", a, 1);
    recvByte(d, 1'b1);
    busStop();
  endtask

  task automatic rdCur(output logic [7:0] d);
    logic a;
    busStart();
    sendByte({7'h2E, 1'b1}, a); chk("R4", a, 1);
    recvByte(d, 1'b1);
    busStop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++; nChecks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      expMem[i] = mem[i];
    end
    mem[8'h20] = 8'h00; expMem[8'h20] = 8'h00;

    // R10 reset state
    doReset(1'b1, 1'b0);
    chk("R10", sdaOe, 0);
    chk("R10", regWrEn, 0);
    chk("R10", regAddr, 0);
    rdCur(d);
    chk("R10", d, expMem[0]);

    // R1 / R2: strap sweep, then strap change after the address is fixed
    for (int c = 0; c < 4; c++) begin
      logic en, sel;
      logic [6:0] ea, na;
      en = c[1]; sel = c[0];
      ea = expAddr(en, sel);
      doReset(en, sel);
      for (int a = 8'h2C; a <= 8'h2F; a++) begin
        probe(7'(a), ack);
        chk("R1", ack, (7'(a) == ea) ? 1 : 0);
      end
      strapEn = ~en; strapSel = ~sel;
      na = expAddr(~en, ~sel);
      probe(ea, ack); chk("R2", ack, 1);
      probe(na, ack); chk("R2", ack, 0);
    end

    // R3 write sweep, read back through repeated start
    doReset(1'b1, 1'b0);
    for (int p = 0; p < 16; p++) begin
      logic [7:0] pa, dv;
      pa = 8'((p * 17) & 8'h3F);
      dv = 8'(p * 37 + 11);
      wrByte(pa, dv, "R3");
      expMem[pa] = dv;
      rdAt(pa, d);
      chk("R3", d, expMem[pa]);
    end

    // R4 repeated reads leave the pointer alone
    rdCur(d); chk("R4", d, expMem[8'h3F & 8'(15 * 17)]);
    rdCur(d); chk("R4", d, expMem[8'h3F & 8'(15 * 17)]);

    // R5 send-byte only
    busStart();
    sendByte({7'h2E, 1'b0}, ack); chk("R5", ack, 1);
    sendByte(8'h31, ack);         chk("R5", ack, 1);
    busStop();
    chk("R5", regAddr, 8'h31);
    rdCur(d); chk("R5", d, expMem[8'h31]);

    // R6 third byte is refused
    busStart();
    sendByte({7'h2E, 1'b0}, ack);
    sendByte(8'h30, ack);
    sendByte(8'h5A, ack); chk("R6", ack, 1);
    sendByte(8'hC3, ack); chk("R6", ack, 0);
    busStop();
    expMem[8'h30] = 8'h5A;
    rdAt(8'h30, d); chk("R6", d, 8'h5A);

    // R8 timeout disabled: data line held
    busStart();
    sendByte({7'h2E, 1'b0}, ack);
    sendByte(8'h20, ack);
    busStart();
    sendByte({7'h2E, 1'b1}, ack);
    waitc(2 * TO_CYC + 50);
    chk("R8", sdaOe, 1);
    recvByte(d, 1'b1);
    busStop();
    chk("R8", d, 8'h00);
    // enable it and hold again
    wrByte(8'h40, 8'h40, "R8");
    expMem[8'h40] = 8'h40;
    busStart();
    sendByte({7'h2E, 1'b0}, ack);
    sendByte(8'h20, ack);
    busStart();
    sendByte({7'h2E, 1'b1}, ack);
    waitc(5);
    chk("R8", sdaOe, 1);
    waitc(TO_CYC + 50);
    chk("R8", sdaOe, 0);
    busStop();
    rdAt(8'h20, d); chk("R8", d, 8'h00);

    // R9 lock
    wrByte(8'h45, 8'h33, "R9");
    expMem[8'h45] = 8'h33;
    wrByte(8'h40, 8'h42, "R9");
    expMem[8'h40] = 8'h42;
    rdAt(8'h40, d); chk("R9", d, 8'h42);
    wrByte(8'h45, 8'h99, "R9");
    rdAt(8'h45, d); chk("R9", d, 8'h33);
    wrByte(8'h40, 8'h00, "R9");
    rdAt(8'h40, d); chk("R9", d, 8'h42);
    wrByte(8'h7F, 8'h12, "R9");
    rdAt(8'h7F, d); chk("R9", d, expMem[8'h7F]);
    wrByte(8'h10, 8'h77, "R9");
    expMem[8'h10] = 8'h77;
    rdAt(8'h10, d); chk("R9", d, 8'h77);
    // reset clears the lock
    doReset(1'b1, 1'b0);
    wrByte(8'h45, 8'h99, "R9");
    expMem[8'h45] = 8'h99;
    rdAt(8'h45, d); chk("R9", d, 8'h99);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule